// File: doc/BRIEF.md
# Priority Clock Input Selector

This block decides which of two reference clock inputs feeds a downstream PLL. It looks only at one validity flag per input, which alarm monitors elsewhere produce, and it runs on a free-running system clock. The ranking is fixed: input 1 is preferred, input 2 comes next, and holdover is the last resort when neither input can be used. Until some input has been valid at least once after reset, the block asks for the output clocks to be muted.

A mode pin sets the switching policy. In revertive mode the block returns to input 1 as soon as input 1 is valid again. In non-revertive mode the block stays on its current input until that input fails. Both modes leave holdover for the first input that becomes valid, and input 1 wins if both become valid together. The outputs are a registered one-hot select, a holdover flag and a mute flag. In every cycle after reset, exactly one of these is active.

Top module: `refsel_prio`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `mute` is 1, `hold` is 0 and `sel_oh` is 2'b00.
- R2: From the muted start state, the edge that samples input 1 valid (`in_ok[0]`=1) sets `sel_oh`=2'b01. If only input 2 is valid (`in_ok[1]`=1), it sets `sel_oh`=2'b10.
- R3: While neither input is valid after reset, `mute` stays 1 and `sel_oh` stays 2'b00.
- R4: When the active input's valid flag drops, the next edge selects the other input if that input is valid. Otherwise it sets `hold`=1 and `sel_oh`=2'b00.
- R5: In revertive mode (`revert`=1), while input 2 is active and input 1 is valid, the next edge selects input 1.
- R6: In non-revertive mode (`revert`=0), an active input 2 that stays valid remains selected, whether or not input 1 is valid.
- R7: In holdover, the next edge selects the first input found valid. If both are valid in the same cycle, input 1 is chosen.
- R8: After reset, exactly one of `sel_oh[0]`, `sel_oh[1]`, `hold` and `mute` is 1 in every cycle.
- R9: A change of `revert` alone does not move the selection while input 1 is active and valid.
- R10: Once `mute` has dropped, it stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ok | input | 2 | Validity flag per input; bit 0 is input 1, bit 1 is input 2 |
| revert | input | 1 | 1 selects revertive switching, 0 selects non-revertive |
| sel_oh | output | 2 | One-hot active input; bit 0 is input 1, bit 1 is input 2 |
| hold | output | 1 | Holdover in effect |
| mute | output | 1 | Output clocks suppressed; no input valid since reset |

## Verification
Several properties are checked on every cycle: that exactly one output role is active, that mute never comes back after it drops, that an active input 1 is dropped right after its alarm, and the next-cycle moves for revertive return, non-revertive holding and the holdover tie. Only the bench's scenarios can show complete switching paths. These include starting on input 2 and then reverting, falling from input 2 to input 1, holdover when both inputs fail, and that a mode change on its own leaves the selection where it is. A second reset with input 1 already valid is also covered only by the bench.

// File: rtl/refsel_prio.sv
module refsel_prio (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] in_ok,
  input  logic       revert,
  output logic [1:0] sel_oh,
  output logic       hold,
  output logic       mute
);

  typedef enum logic [1:0] {ST_MUTE, ST_IN1, ST_IN2, ST_HOLD} pick_t;

  pick_t cur, nxt;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_MUTE, ST_HOLD: begin
        if (in_ok[0])      nxt = ST_IN1;
        else if (in_ok[1]) nxt = ST_IN2;
      end
      ST_IN1: begin
        if (!in_ok[0]) nxt = in_ok[1] ? ST_IN2 : ST_HOLD;
      end
      ST_IN2: begin
        if (!in_ok[1])                nxt = in_ok[0] ? ST_IN1 : ST_HOLD;
        else if (revert && in_ok[0])  nxt = ST_IN1;
      end
      default: nxt = ST_MUTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= ST_MUTE;
    else        cur <= nxt;
  end

  assign sel_oh = {cur == ST_IN2, cur == ST_IN1};
  assign hold   = (cur == ST_HOLD);
  assign mute   = (cur == ST_MUTE);

  // R8
  a_r8_one_role: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_oh, hold, mute}) == 1);

  // R10
  a_r10_no_remute: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |=> !mute);

  // R4
  a_r4_leave_failed: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh[0] && !in_ok[0]) |=> !sel_oh[0]);

  // R5
  a_r5_revert_back: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh[1] && in_ok[0] && revert) |=> sel_oh[0]);

  // R6
  a_r6_keep_active: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh[1] && in_ok[1] && !revert) |=> sel_oh[1]);

  // R7
  a_r7_hold_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && in_ok[0]) |=> sel_oh[0]);

endmodule

// File: tb/refsel_prio_bench.sv
module refsel_prio_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] in_ok = 2'b00;
  logic       revert = 1'b0;
  logic [1:0] sel_oh;
  logic       hold, mute;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  localparam logic [3:0] E_IN1 = 4'b0100, E_IN2 = 4'b1000,
                         E_HOLD = 4'b0010, E_MUTE = 4'b0001;

  always #10 clk = ~clk;

  refsel_prio u_refsel_prio (
    .clk(clk), .rst_n(rst_n), .in_ok(in_ok), .revert(revert),
    .sel_oh(sel_oh), .hold(hold), .mute(mute)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {sel_oh, hold, mute};
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] ok, input logic rv,
                      input logic [3:0] exp, input string tag);
    @(negedge clk);
    in_ok  = ok;
    revert = rv;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic do_reset(input logic [1:0] ok);
    @(negedge clk);
    rst_n = 1'b0;
    in_ok = ok;
    @(negedge clk);
    @(negedge clk);
    check(E_MUTE, "R1 in reset");
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(2'b00);
    step(2'b00, 1'b1, E_MUTE, "R3 none valid");
    step(2'b00, 1'b1, E_MUTE, "R3 still none");
    step(2'b10, 1'b0, E_IN2,  "R2 only input 2");
    step(2'b11, 1'b0, E_IN2,  "R6 keep input 2");
    step(2'b11, 1'b0, E_IN2,  "R6 keep input 2 again");
    step(2'b11, 1'b1, E_IN1,  "R5 revert to input 1");
    step(2'b01, 1'b0, E_IN1,  "R9 mode change only");
    step(2'b11, 1'b1, E_IN1,  "R9 mode back");
    step(2'b10, 1'b1, E_IN2,  "R4 input 1 alarm");
    step(2'b00, 1'b1, E_HOLD, "R4 both fail");
    step(2'b00, 1'b1, E_HOLD, "R10 hold not mute");
    step(2'b11, 1'b0, E_IN1,  "R7 tie to input 1");
    step(2'b00, 1'b0, E_HOLD, "R4 to hold");
    step(2'b10, 1'b0, E_IN2,  "R7 first valid input 2");
    step(2'b11, 1'b0, E_IN2,  "R6 stay on 2");
    step(2'b01, 1'b0, E_IN1,  "R4 input 2 alarm");
    step(2'b00, 1'b1, E_HOLD, "R4 hold again");
    step(2'b10, 1'b1, E_IN2,  "R7 revertive first valid");
    step(2'b11, 1'b1, E_IN1,  "R5 revert from 2");
    @(negedge clk);
    @(negedge clk);
    do_reset(2'b11);
    check(E_MUTE, "R1 after release");
    step(2'b11, 1'b0, E_IN1,  "R2 both valid picks 1");
    step(2'b00, 1'b0, E_HOLD, "R10 no mute after start");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule